// File: doc/BRIEF.md
# Scan-Loop Register Self-Test Controller

This block runs a built-in stuck-at test over a scannable register chain while keeping the chain's functional contents. At other times it is transparent. The global scan input feeds the chain head, the global shift enable drives the chain shift, and the chain tail appears at the global scan output. The functional clock enable of the chain passes through unchanged.

A test begins with a start pulse. The controller first takes the chain off the global scan path. It then closes the chain into a ring through two internal pattern registers, each `PAT_W` bits wide. One of these is filled with zeros and the other with ones. The ring then rotates for exactly `CHAIN_LEN + 2*PAT_W` shift cycles, so every bit comes back to where it started. Both patterns are then compared. A chain cell stuck at 0 clears a bit of the ones pattern as it passes. A cell stuck at 1 sets a bit of the zeros pattern. Either case is reported through `fail`. The rotation is a full turn, so the functional values end up back in their own cells with no save or restore.

The chain connects as follows. `chain_si` feeds the chain head (bit 0). The chain moves one place toward its tail on each cycle that `chain_shift` is high. The tail bit returns on `chain_so`.

Top module: `scanloop_bist`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are all low.
- R2: While `busy` is low, `chain_shift` follows `scan_en`, `chain_si` follows `scan_in`, `scan_out` follows `chain_so`, and `func_en_out` follows `func_en_in`.
- R3: A start pulse sampled while idle raises `busy` from the following cycle. `busy` then stays high for exactly `CHAIN_LEN + 2*PAT_W + 2` cycles: one load cycle, the shift cycles and one compare cycle.
- R4: During a test, `chain_shift` is high for exactly `CHAIN_LEN + 2*PAT_W` cycles.
- R5: While `busy` is high, `func_en_out` is low whatever `func_en_in` is.
- R6: While `busy` is high, `scan_in` and `scan_en` have no effect on the chain, and `scan_out` is driven low.
- R7: After a test on a fault-free chain, every chain cell holds the value it held before the start pulse.
- R8: `done` is high for exactly one cycle, the cycle after `busy` falls. On a fault-free chain `fail` is low at that point.
- R9: If any single chain cell is stuck at 0 or stuck at 1, `fail` is high when `done` is asserted.
- R10: `fail` keeps its value until the next accepted start pulse. It reads low from the cycle after that pulse is accepted.
- R11: A start pulse while `busy` is high is ignored, and the running test keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a self-test (single-cycle pulse) |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test strobe |
| fail | output | 1 | Result of the last test: high if a pattern was corrupted |
| scan_en | input | 1 | Global scan shift enable |
| scan_in | input | 1 | Global scan serial input |
| scan_out | output | 1 | Global scan serial output |
| chain_shift | output | 1 | Shift enable to the protected chain |
| chain_si | output | 1 | Serial data into the chain head |
| chain_so | input | 1 | Serial data from the chain tail |
| func_en_in | input | 1 | Functional update enable from the system |
| func_en_out | output | 1 | Functional update enable to the chain, gated during a test |

## Verification
The assertions assume that the chain moves exactly one place per cycle on `chain_shift` and that nothing else changes it while `func_en_out` is low. They also assume `start` is a synchronous level sampled on the clock. The bench chain model follows these rules. Its stuck-at cells are forced only through masks that the bench changes between tests. Throughout each test the bench drives random `scan_in`, holds `scan_en` and `func_en_in` high, and pulses `start` part-way through one run. This exercises the ignore paths without breaking those assumptions.

// File: rtl/scanloop_pkg.sv
package scanloop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_CHECK = 2'd3
    } loop_state_e;

endpackage

// File: rtl/scanloop_seq.sv
module scanloop_seq
    import scanloop_pkg::*;
#(
    parameter int TOTAL = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pat_ok,
    output logic busy,
    output logic load,
    output logic shift,
    output logic done,
    output logic fail
);

    localparam int CW = $clog2(TOTAL + 1);

    typedef struct packed {
        loop_state_e     st;
        logic [CW-1:0]   cnt;
        logic            done;
        logic            fail;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st   = ST_LOAD;
                    seq_d.fail = 1'b0;
                end
            end
            ST_LOAD: begin
                seq_d.st  = ST_SHIFT;
                seq_d.cnt = CW'(TOTAL - 1);
            end
            ST_SHIFT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_CHECK;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_CHECK: begin
                seq_d.st   = ST_IDLE;
                seq_d.fail = ~pat_ok;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, done: 1'b0, fail: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy  = (seq_q.st != ST_IDLE);
    assign load  = (seq_q.st == ST_LOAD);
    assign shift = (seq_q.st == ST_SHIFT);
    assign done  = seq_q.done;
    assign fail  = seq_q.fail;

endmodule

// File: rtl/scanloop_patregs.sv
module scanloop_patregs #(
    parameter int PAT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic shift,
    input  logic ring_in,
    output logic ring_out,
    output logic pat_ok
);

    typedef struct packed {
        logic [PAT_W-1:0] zeros;
        logic [PAT_W-1:0] ones;
    } pat_t;

    pat_t pat_d, pat_q;
    logic [PAT_W-1:0] zeros_sh, ones_sh;

    generate
        if (PAT_W == 1) begin : g_single
            assign zeros_sh = ring_in;
            assign ones_sh  = pat_q.zeros;
        end else begin : g_multi
            assign zeros_sh = {pat_q.zeros[PAT_W-2:0], ring_in};
            assign ones_sh  = {pat_q.ones[PAT_W-2:0], pat_q.zeros[PAT_W-1]};
        end
    endgenerate

    always_comb begin
        pat_d = pat_q;
        if (load) begin
            pat_d.zeros = '0;
            pat_d.ones  = '1;
        end else if (shift) begin
            pat_d.zeros = zeros_sh;
            pat_d.ones  = ones_sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '{zeros: '0, ones: '1};
        end else begin
            pat_q <= pat_d;
        end
    end

    assign ring_out = pat_q.ones[PAT_W-1];
    assign pat_ok   = (pat_q.zeros == '0) && (pat_q.ones == '1);

endmodule

// File: rtl/scanloop_bist.sv
module scanloop_bist #(
    parameter int CHAIN_LEN = 24,
    parameter int PAT_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic fail,
    input  logic scan_en,
    input  logic scan_in,
    output logic scan_out,
    output logic chain_shift,
    output logic chain_si,
    input  logic chain_so,
    input  logic func_en_in,
    output logic func_en_out
);

    localparam int TOTAL = CHAIN_LEN + 2 * PAT_W;

    logic load, shift, pat_ok, ring_out;

    scanloop_seq #(.TOTAL(TOTAL)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .pat_ok (pat_ok),
        .busy   (busy),
        .load   (load),
        .shift  (shift),
        .done   (done),
        .fail   (fail)
    );

    scanloop_patregs #(.PAT_W(PAT_W)) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .ring_in  (chain_so),
        .ring_out (ring_out),
        .pat_ok   (pat_ok)
    );

    always_comb begin
        if (busy) begin
            chain_si    = ring_out;
            chain_shift = shift;
            scan_out    = 1'b0;
            func_en_out = 1'b0;
        end else begin
            chain_si    = scan_in;
            chain_shift = scan_en;
            scan_out    = chain_so;
            func_en_out = func_en_in;
        end
    end

endmodule

// File: rtl/scanloop_bist_chk.sv
module scanloop_bist_chk #(
    parameter int CHAIN_LEN = 24,
    parameter int PAT_W     = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic fail,
    input logic scan_en,
    input logic scan_out,
    input logic chain_shift,
    input logic func_en_in,
    input logic func_en_out
);

    localparam int TOTAL = CHAIN_LEN + 2 * PAT_W;

    logic [15:0] shift_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_cnt <= '0;
        end else if (start && !busy) begin
            shift_cnt <= '0;
        end else if (busy && chain_shift) begin
            shift_cnt <= shift_cnt + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!busy && !done && !fail));

    // R2
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (chain_shift == scan_en && func_en_out == func_en_in));

    // R4
    shift_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (shift_cnt == 16'(TOTAL)));

    // R5
    func_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !func_en_out);

    // R6
    scan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !scan_out);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail) |-> (done || $past(start)));

endmodule

bind scanloop_bist scanloop_bist_chk #(.CHAIN_LEN(CHAIN_LEN), .PAT_W(PAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .scan_en     (scan_en),
    .scan_out    (scan_out),
    .chain_shift (chain_shift),
    .func_en_in  (func_en_in),
    .func_en_out (func_en_out)
);

// File: tb/tb_scanloop_bist.sv
module tb_scanloop_bist;

    localparam int L     = 24;
    localparam int W     = 4;
    localparam int TOTAL = L + 2 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, scan_en = 1'b0, scan_in = 1'b0, func_en_in = 1'b0;
    logic busy, done, fail, scan_out, chain_shift, chain_si, chain_so, func_en_out;

    logic [L-1:0] chain_q = '0, chain_nx, sa0_m = '0, sa1_m = '0, func_d = '0;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    scanloop_bist #(.CHAIN_LEN(L), .PAT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
        .chain_shift(chain_shift), .chain_si(chain_si), .chain_so(chain_so),
        .func_en_in(func_en_in), .func_en_out(func_en_out)
    );

    // chain model with stuck-at injection
    always @(posedge clk) begin
        chain_nx = chain_q;
        if (chain_shift) chain_nx = {chain_q[L-2:0], chain_si};
        else if (func_en_out) chain_nx = func_d;
        chain_q <= (chain_nx & ~sa0_m) | sa1_m;
    end
    assign chain_so = chain_q[L-1];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            misses = misses + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [L-1:0] v);
        func_d = v; func_en_in = 1'b1;
        @(negedge clk);
        func_en_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_test(input bit exp_fail, input bit mid_start);
        int nb = 0, ns = 0, bad_fen = 0, bad_so = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(fail == 1'b0, "R10", fail, 0);
        chk(busy == 1'b1, "R3", busy, 1);
        while (!done && nb < TOTAL + 50) begin
            if (busy) nb++;
            if (chain_shift) ns++;
            if (func_en_out) bad_fen++;
            if (scan_out) bad_so++;
            start      = (mid_start && nb == 10);
            scan_in    = 1'($urandom);
            scan_en    = 1'b1;
            func_en_in = 1'b1;
            @(negedge clk);
        end
        start = 1'b0; scan_en = 1'b0; func_en_in = 1'b0;
        chk(nb == TOTAL + 2, mid_start ? "R11" : "R3", nb, TOTAL + 2);
        chk(ns == TOTAL, "R4", ns, TOTAL);
        chk(bad_fen == 0, "R5", bad_fen, 0);
        chk(bad_so == 0, "R6", bad_so, 0);
        chk(done == 1'b1, "R8", done, 1);
        chk(fail == exp_fail, exp_fail ? "R9" : "R8", fail, exp_fail);
        @(negedge clk);
        chk(done == 1'b0, "R8", done, 0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !fail, "R1", {busy, done, fail}, 0);
    endtask

    task automatic t_passthru;
        scan_en = 1'b1; scan_in = 1'b1; func_en_in = 1'b0;
        #1;
        chk(chain_shift == 1'b1 && chain_si == 1'b1, "R2", {chain_shift, chain_si}, 2'b11);
        scan_en = 1'b0; scan_in = 1'b0; func_en_in = 1'b1;
        #1;
        chk(chain_shift == 1'b0 && chain_si == 1'b0 && func_en_out == 1'b1, "R2",
            {chain_shift, chain_si, func_en_out}, 3'b001);
        chk(scan_out == chain_so, "R2", scan_out, chain_so);
        func_en_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_clean(input logic [L-1:0] v, input bit mid_start);
        logic [L-1:0] saved;
        preload(v);
        saved = chain_q;
        run_test(1'b0, mid_start);
        chk(chain_q == saved, "R7", chain_q, saved);
        chk(chain_q == saved, "R6", chain_q, saved);
    endtask

    task automatic t_stuck(input bit one, input int pos);
        preload(24'h5a3c96);
        if (one) sa1_m[pos] = 1'b1; else sa0_m[pos] = 1'b1;
        run_test(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk(fail == 1'b1, "R10", fail, 1);
        sa0_m = '0; sa1_m = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_clean(24'ha5c3f0, 1'b0);
        t_clean(24'h000001, 1'b1);
        t_clean(24'hffffff, 1'b0);
        t_stuck(1'b0, 5);
        t_clean(24'h123456, 1'b0);
        t_stuck(1'b1, L - 1);
        t_stuck(1'b1, 0);
        t_stuck(1'b0, 0);
        t_clean(24'h0f0f0f, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule